// File: doc/BRIEF.md
# Twelve-Bit Memory-Reference Instruction Core

This block is the sequencing and data path for the memory-reference instructions of a 12-bit machine with a single accumulator. It fetches one-word instructions over a synchronous, word-addressed memory port. It forms an effective address from a 7-bit in-page offset. It then runs one of six operations: bitwise AND, two's-complement add, increment-and-skip-if-zero, store-and-clear, jump-to-subroutine and jump. The machine has no load instruction. A value is loaded by adding it into an accumulator that a previous store has cleared.

Addresses are 15 bits wide. A 3-bit code field is placed in front of the 12-bit program counter, and of pointer and jump addresses. A 3-bit data field is placed in front of operand addresses that are reached through a pointer. Both fields are taken from boot inputs while reset is held, together with the start address. A pointer fetched from one of eight reserved page-zero cells is incremented and written back before it is used, which gives memory-resident index registers.

The controller steps through six named states: FETCH, DECODE, PTR_RD, PTR_UPD, ACT and OPND. Each fetch ends in a single-cycle retire pulse. After that pulse the accumulator, link and program counter outputs show the architectural state.

Top module: `mri_core`

## Requirements
- R1: While `rst` is high the core loads `boot_pc_i`, `boot_ifield_i` and `boot_dfield_i` and clears the accumulator and link. In the first cycle after reset it reads memory at {code field, start address}.
- R2: Instruction bits [11:9] are the opcode (0 AND, 1 add, 2 increment-skip, 3 store-clear, 4 call, 5 jump, 6 and 7 no-op). Bit 8 selects indirect. Bit 7 selects the page of the instruction itself instead of page zero. Bits [6:0] are the word offset within a 128-word page.
- R3: Add puts the 12-bit sum of accumulator and operand in the accumulator. A carry out of the top bit inverts the link.
- R4: AND puts the bitwise AND of accumulator and operand in the accumulator and leaves the link unchanged.
- R5: Store-clear writes the accumulator to the effective address, then sets the accumulator to zero.
- R6: Increment-skip writes operand+1 (mod 4096) back. When that value is zero, the next instruction is skipped.
- R7: Call writes the return address (instruction address + 1) into the target word and continues at target + 1. Jump continues at the target.
- R8: An indirect reference reads its pointer from the code field. Data operations then use the data field with the pointer as the address. Call and jump stay in the code field.
- R9: When the pointer cell is at address 010 to 017 (octal), the pointer is incremented, written back, and the new value is used. Pointers in other cells are left unchanged.
- R10: From fetch to retire an instruction takes 2 cycles (no-op), 3 cycles (store-clear, call, jump) or 4 cycles (AND, add, increment-skip). Indirect addressing adds 2 cycles. The next fetch follows the retire cycle.
- R11: The program counter wraps from 7777 to 0000 (octal) inside the code field. The field does not change.
- R12: Opcodes 6 and 7 change neither accumulator, link nor memory. They only advance the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; boot values are sampled while high |
| boot_pc_i | input | 12 | Start address |
| boot_ifield_i | input | 3 | Code field loaded at reset |
| boot_dfield_i | input | 3 | Data field loaded at reset |
| mem_addr_o | output | 15 | Word address {field, 12-bit address} |
| mem_rd_o | output | 1 | Read request; data is returned one cycle later |
| mem_wr_o | output | 1 | Write request, taken at the clock edge |
| mem_wdata_o | output | 12 | Write data |
| mem_rdata_i | input | 12 | Read data for the request of the previous cycle |
| retire_o | output | 1 | High in the last cycle of each instruction |
| acc_o | output | 12 | Accumulator |
| link_o | output | 1 | Link bit |
| pc_o | output | 12 | Program counter |

## Verification
The hardest case to reach from the ports is a pointer cell in the auto-increment window whose update wraps 7777 to 0000. The effective address then lands on word zero of the data field, which an earlier increment-skip has just modified through a second auto-increment cell. A directed program with different code and data fields reaches that chain. It starts two words below the top of the field, so the program counter also wraps. Randomised AND, add and store-clear programs are checked instruction by instruction against an architectural reference model, including the cycle count between retire pulses.

// File: rtl/mri_pkg.sv
package mri_pkg;
    localparam int WORD_W = 12;
    localparam int FLD_W  = 3;
    localparam int OFF_W  = 7;
    localparam int OP_W   = 3;
    localparam int ADDR_W = FLD_W + WORD_W;
    localparam int PAGE_W = WORD_W - OFF_W;
    localparam int IND_B  = OFF_W + 1;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [FLD_W-1:0]  fld_t;

    typedef enum logic [OP_W-1:0] {
        OP_AND  = 3'd0,
        OP_TAD  = 3'd1,
        OP_ISZ  = 3'd2,
        OP_DCA  = 3'd3,
        OP_JMS  = 3'd4,
        OP_JMP  = 3'd5,
        OP_NOP6 = 3'd6,
        OP_NOP7 = 3'd7
    } opcode_t;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_PTR_RD,
        ST_PTR_UPD,
        ST_ACT,
        ST_OPND
    } state_t;
endpackage

// File: rtl/mri_addr_gen.sv
module mri_addr_gen
    import mri_pkg::*;
#(
    parameter int AUTO_LO = 8,
    parameter int AUTO_N  = 8
) (
    input  word_t instr,
    input  word_t pc,
    input  word_t ea_q,
    input  word_t ptr_word,
    output word_t page_ea,
    output logic  is_auto,
    output word_t ptr_next
);
    logic [AUTO_N-1:0] hit;

    // page select: bit OFF_W picks the instruction's own page
    assign page_ea = instr[OFF_W] ? {pc[WORD_W-1:OFF_W], instr[OFF_W-1:0]}
                                  : {{PAGE_W{1'b0}}, instr[OFF_W-1:0]};

    for (genvar g = 0; g < AUTO_N; g++) begin : g_auto
        assign hit[g] = (ea_q == word_t'(AUTO_LO + g));
    end

    assign is_auto  = |hit;
    assign ptr_next = is_auto ? ptr_word + word_t'(1) : ptr_word;
endmodule

// File: rtl/mri_alu.sv
module mri_alu
    import mri_pkg::*;
(
    input  opcode_t op,
    input  word_t   acc,
    input  logic    link,
    input  word_t   opnd,
    output word_t   acc_nx,
    output logic    link_nx,
    output word_t   inc_val,
    output logic    inc_zero
);
    logic [WORD_W:0] sum;

    assign sum      = {1'b0, acc} + {1'b0, opnd};
    assign inc_val  = opnd + word_t'(1);
    assign inc_zero = (inc_val == '0);

    always_comb begin
        acc_nx  = acc;
        link_nx = link;
        case (op)
            OP_AND: acc_nx = acc & opnd;
            OP_TAD: begin
                acc_nx  = sum[WORD_W-1:0];
                link_nx = link ^ sum[WORD_W];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mri_ctrl.sv
module mri_ctrl
    import mri_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  opcode_t op,
    input  logic    ind,
    output state_t  state
);
    state_t state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH:   state_nx = ST_DECODE;
            ST_DECODE: begin
                if (op == OP_NOP6 || op == OP_NOP7) state_nx = ST_FETCH;
                else if (ind)                       state_nx = ST_PTR_RD;
                else                                state_nx = ST_ACT;
            end
            ST_PTR_RD:  state_nx = ST_PTR_UPD;
            ST_PTR_UPD: state_nx = ST_ACT;
            ST_ACT: begin
                if (op == OP_AND || op == OP_TAD || op == OP_ISZ) state_nx = ST_OPND;
                else                                              state_nx = ST_FETCH;
            end
            ST_OPND:    state_nx = ST_FETCH;
            default:    state_nx = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mri_core.sv
module mri_core
    import mri_pkg::*;
#(
    parameter int AUTO_LO = 8,
    parameter int AUTO_N  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [WORD_W-1:0]       boot_pc_i,
    input  logic [FLD_W-1:0]        boot_ifield_i,
    input  logic [FLD_W-1:0]        boot_dfield_i,
    output logic [ADDR_W-1:0]       mem_addr_o,
    output logic                    mem_rd_o,
    output logic                    mem_wr_o,
    output logic [WORD_W-1:0]       mem_wdata_o,
    input  logic [WORD_W-1:0]       mem_rdata_i,
    output logic                    retire_o,
    output logic [WORD_W-1:0]       acc_o,
    output logic                    link_o,
    output logic [WORD_W-1:0]       pc_o
);
    state_t  state;
    word_t   ir_q, pc_q, acc_q, ea_q;
    logic    link_q;
    fld_t    ifld_q, dfld_q, tgt_fld;
    word_t   cur_word, page_ea, ptr_next, acc_nx, inc_val;
    opcode_t op_cur;
    logic    ind_cur, is_auto, link_nx, inc_zero;

    // in DECODE the instruction is still on the read bus
    assign cur_word = (state == ST_DECODE) ? mem_rdata_i : ir_q;
    assign op_cur   = opcode_t'(cur_word[WORD_W-1:WORD_W-OP_W]);
    assign ind_cur  = cur_word[IND_B];
    assign tgt_fld  = (op_cur == OP_JMS || op_cur == OP_JMP || !ind_cur) ? ifld_q : dfld_q;

    mri_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .op    (op_cur),
        .ind   (ind_cur),
        .state (state)
    );

    mri_addr_gen #(
        .AUTO_LO (AUTO_LO),
        .AUTO_N  (AUTO_N)
    ) u_addr (
        .instr    (cur_word),
        .pc       (pc_q),
        .ea_q     (ea_q),
        .ptr_word (mem_rdata_i),
        .page_ea  (page_ea),
        .is_auto  (is_auto),
        .ptr_next (ptr_next)
    );

    mri_alu u_alu (
        .op       (op_cur),
        .acc      (acc_q),
        .link     (link_q),
        .opnd     (mem_rdata_i),
        .acc_nx   (acc_nx),
        .link_nx  (link_nx),
        .inc_val  (inc_val),
        .inc_zero (inc_zero)
    );

    // output process: memory strobes and retire per state
    always_comb begin
        mem_rd_o    = 1'b0;
        mem_wr_o    = 1'b0;
        mem_addr_o  = {ifld_q, pc_q};
        mem_wdata_o = acc_q;
        retire_o    = 1'b0;
        unique case (state)
            ST_FETCH:  mem_rd_o = 1'b1;
            ST_DECODE: retire_o = (op_cur == OP_NOP6) || (op_cur == OP_NOP7);
            ST_PTR_RD: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = {ifld_q, ea_q};
            end
            ST_PTR_UPD: begin
                mem_wr_o    = is_auto;
                mem_addr_o  = {ifld_q, ea_q};
                mem_wdata_o = ptr_next;
            end
            ST_ACT: begin
                mem_addr_o = {tgt_fld, ea_q};
                case (op_cur)
                    OP_AND, OP_TAD, OP_ISZ: mem_rd_o = 1'b1;
                    OP_DCA: begin
                        mem_wr_o = 1'b1;
                        retire_o = 1'b1;
                    end
                    OP_JMS: begin
                        mem_wr_o    = 1'b1;
                        mem_wdata_o = pc_q;
                        retire_o    = 1'b1;
                    end
                    OP_JMP:  retire_o = 1'b1;
                    default: ;
                endcase
            end
            ST_OPND: begin
                mem_addr_o  = {tgt_fld, ea_q};
                mem_wdata_o = inc_val;
                mem_wr_o    = (op_cur == OP_ISZ);
                retire_o    = 1'b1;
            end
            default: ;
        endcase
    end

    // architectural and sequencing registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= boot_pc_i;
            ifld_q <= boot_ifield_i;
            dfld_q <= boot_dfield_i;
            acc_q  <= '0;
            link_q <= 1'b0;
            ir_q   <= '0;
            ea_q   <= '0;
        end else begin
            case (state)
                ST_DECODE: begin
                    ir_q <= mem_rdata_i;
                    pc_q <= pc_q + word_t'(1);
                    ea_q <= page_ea;
                end
                ST_PTR_UPD: ea_q <= ptr_next;
                ST_ACT: begin
                    case (op_cur)
                        OP_DCA:  acc_q <= '0;
                        OP_JMS:  pc_q  <= ea_q + word_t'(1);
                        OP_JMP:  pc_q  <= ea_q;
                        default: ;
                    endcase
                end
                ST_OPND: begin
                    if (op_cur == OP_ISZ) begin
                        if (inc_zero) pc_q <= pc_q + word_t'(1);
                    end else begin
                        acc_q  <= acc_nx;
                        link_q <= link_nx;
                    end
                end
                default: ;
            endcase
        end
    end

    assign acc_o  = acc_q;
    assign link_o = link_q;
    assign pc_o   = pc_q;
endmodule

// File: rtl/mri_core_chk.sv
module mri_core_chk
    import mri_pkg::*;
#(
    parameter int AUTO_LO = 8,
    parameter int AUTO_N  = 8
) (
    input logic              clk,
    input logic              rst,
    input state_t            state,
    input opcode_t           op,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              retire,
    input word_t             acc,
    input logic              link,
    input word_t             pc,
    input word_t             ea,
    input fld_t              ifld
);
    a_r10_one_access: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    a_r10_fetch_follows: assert property (@(posedge clk) disable iff (rst)
        retire |=> (mem_rd && mem_addr == {ifld, pc}));

    a_r5_store_clears: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACT && op == OP_DCA) |=> (acc == '0));

    a_r4_and_keeps_link: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OPND && op == OP_AND) |=> $stable(link));

    a_r7_jump_target: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACT && op == OP_JMP) |=> (pc == $past(ea)));

    a_r12_noop_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECODE && retire) |=> ($stable(acc) && $stable(link)));

    a_r9_window_only: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PTR_UPD && mem_wr) |->
            (mem_addr[WORD_W-1:0] >= word_t'(AUTO_LO) &&
             mem_addr[WORD_W-1:0] <  word_t'(AUTO_LO + AUTO_N)));
endmodule

bind mri_core mri_core_chk #(.AUTO_LO(AUTO_LO), .AUTO_N(AUTO_N)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .state    (state),
    .op       (op_cur),
    .mem_rd   (mem_rd_o),
    .mem_wr   (mem_wr_o),
    .mem_addr (mem_addr_o),
    .retire   (retire_o),
    .acc      (acc_q),
    .link     (link_q),
    .pc       (pc_q),
    .ea       (ea_q),
    .ifld     (ifld_q)
);

// File: tb/test_mri_core.sv
module test_mri_core;
    import mri_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] boot_pc = '0;
    logic [2:0]  boot_if = '0, boot_df = '0;
    logic [14:0] mem_addr;
    logic        mem_rd, mem_wr, retire, link;
    logic [11:0] mem_wdata, mem_rdata, acc, pc;

    always #4 clk = ~clk;

    mri_core i_mri_core (
        .clk(clk), .rst(rst), .boot_pc_i(boot_pc), .boot_ifield_i(boot_if),
        .boot_dfield_i(boot_df), .mem_addr_o(mem_addr), .mem_rd_o(mem_rd),
        .mem_wr_o(mem_wr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .retire_o(retire), .acc_o(acc), .link_o(link), .pc_o(pc)
    );

    logic [11:0] dmem [int];
    logic [11:0] rmem [int];

    always @(posedge clk) begin
        if (mem_wr) dmem[int'(mem_addr)] = mem_wdata;
        if (mem_rd) mem_rdata <= dmem.exists(int'(mem_addr)) ? dmem[int'(mem_addr)] : 12'd0;
    end

    typedef struct {
        logic [11:0] pc;
        logic [11:0] ac;
        logic        lnk;
        int          cyc;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    exp_t cur;
    int n_chk = 0, n_fail = 0, wd = 0, cyc_cnt = 0, gap = 0;
    bit pend = 0;

    logic [11:0] r_pc, r_ac;
    logic        r_lnk;
    logic [2:0]  r_if, r_df;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0o expected %0o", req, what, act, expv);
        end
    endtask

    function automatic logic [11:0] mk(int op, bit ind, bit cp, int off);
        logic [2:0] o = op[2:0];
        logic [6:0] f = off[6:0];
        return {o, ind, cp, f};
    endfunction

    task automatic poke(input logic [2:0] f, input logic [11:0] a, input logic [11:0] v);
        dmem[int'({f, a})] = v;
        rmem[int'({f, a})] = v;
    endtask

    function automatic logic [11:0] rget(input logic [14:0] a);
        return rmem.exists(int'(a)) ? rmem[int'(a)] : 12'd0;
    endfunction

    // architectural reference: one instruction per call
    task automatic ref_step(output exp_t e);
        logic [11:0] w, ea, ptr, pcn, v;
        logic [12:0] s;
        logic [2:0]  op, fld;
        logic        ind, cp;
        int          cyc;
        string       tag;
        w   = rget({r_if, r_pc});
        op  = w[11:9];
        ind = w[8];
        cp  = w[7];
        ea  = cp ? {r_pc[11:7], w[6:0]} : {5'd0, w[6:0]};
        pcn = r_pc + 12'd1;
        tag = (r_pc == 12'o7777) ? "R11 " : "";
        cyc = 2;
        if (op >= 3'd6) begin
            tag = {tag, "R12"};
        end else begin
            if (cp) tag = {tag, "R2 "};
            if (ind) begin
                ptr = rget({r_if, ea});
                if (ea >= 12'o10 && ea <= 12'o17) begin
                    ptr = ptr + 12'd1;
                    rmem[int'({r_if, ea})] = ptr;
                    tag = {tag, "R9 "};
                end
                tag = {tag, "R8 "};
                ea  = ptr;
                cyc = cyc + 2;
            end
            fld = (op == 3'd4 || op == 3'd5 || !ind) ? r_if : r_df;
            case (op)
                3'd0: begin r_ac = r_ac & rget({fld, ea}); cyc += 2; tag = {tag, "R4"}; end
                3'd1: begin
                    s = {1'b0, r_ac} + {1'b0, rget({fld, ea})};
                    r_ac = s[11:0]; r_lnk = r_lnk ^ s[12]; cyc += 2; tag = {tag, "R3"};
                end
                3'd2: begin
                    v = rget({fld, ea}) + 12'd1;
                    rmem[int'({fld, ea})] = v;
                    if (v == 12'd0) pcn = pcn + 12'd1;
                    cyc += 2; tag = {tag, "R6"};
                end
                3'd3: begin rmem[int'({fld, ea})] = r_ac; r_ac = '0; cyc += 1; tag = {tag, "R5"}; end
                3'd4: begin rmem[int'({r_if, ea})] = pcn; pcn = ea + 12'd1; cyc += 1; tag = {tag, "R7"}; end
                default: begin pcn = ea; cyc += 1; tag = {tag, "R7"}; end
            endcase
        end
        r_pc  = pcn;
        e.pc  = r_pc;
        e.ac  = r_ac;
        e.lnk = r_lnk;
        e.cyc = cyc;
        e.tag = tag;
    endtask

    // monitor: each retire is compared one cycle later against the scoreboard
    always @(negedge clk) begin
        if (rst) begin
            cyc_cnt = 0;
            pend    = 0;
        end else begin
            cyc_cnt++;
            if (pend && sbq.size() > 0) begin
                cur = sbq.pop_front();
                chk(pc == cur.pc, cur.tag, "pc", 32'(pc), 32'(cur.pc));
                chk(acc == cur.ac, cur.tag, "acc", 32'(acc), 32'(cur.ac));
                chk(link == cur.lnk, cur.tag, "link", 32'(link), 32'(cur.lnk));
                if (cur.cyc > 0)
                    chk(gap == cur.cyc, {"R10 ", cur.tag}, "cycles", 32'(gap), 32'(cur.cyc));
            end
            pend = 0;
            if (retire) begin
                pend    = 1;
                gap     = cyc_cnt;
                cyc_cnt = 0;
            end
        end
    end

    // driver: fills the scoreboard from the reference and starts the core
    task automatic run_prog(input logic [11:0] spc, input logic [2:0] fi,
                            input logic [2:0] fd, input int steps);
        exp_t e;
        int   mism = 0;
        @(negedge clk);
        rst = 1'b1;
        boot_pc = spc; boot_if = fi; boot_df = fd;
        r_pc = spc; r_if = fi; r_df = fd; r_ac = '0; r_lnk = 1'b0;
        for (int k = 0; k < steps; k++) begin
            ref_step(e);
            if (k == 0) e.cyc = 0;
            sbq.push_back(e);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(pc == spc && acc == 12'd0 && link == 1'b0, "R1", "reset state pc",
            32'(pc), 32'(spc));
        chk(mem_rd && mem_addr == {fi, spc}, "R1", "first fetch address",
            32'(mem_addr), 32'({fi, spc}));
        wait (sbq.size() == 0);
        rst = 1'b1;
        @(negedge clk);
        foreach (rmem[a]) if (!dmem.exists(a) || dmem[a] !== rmem[a]) mism++;
        chk(mism == 0, "R5 R6 R7 R9", "memory image mismatches", 32'(mism), 32'd0);
        dmem.delete();
        rmem.delete();
    endtask

    always @(negedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog: actual %0d cycles expected completion", wd);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // program A: arithmetic, store-clear, increment-skip, call/return
        poke(0, 12'o0200, mk(1, 0, 1, 7'o50));
        poke(0, 12'o0201, mk(1, 0, 0, 7'o30));
        poke(0, 12'o0202, mk(1, 0, 0, 7'o31));
        poke(0, 12'o0203, mk(0, 0, 0, 7'o32));
        poke(0, 12'o0204, mk(3, 0, 0, 7'o33));
        poke(0, 12'o0205, mk(1, 0, 0, 7'o33));
        poke(0, 12'o0206, mk(2, 0, 0, 7'o34));
        poke(0, 12'o0207, mk(2, 0, 0, 7'o34));
        poke(0, 12'o0210, mk(1, 0, 0, 7'o30));
        poke(0, 12'o0211, mk(4, 0, 1, 7'o60));
        poke(0, 12'o0212, 12'o6000);
        poke(0, 12'o0213, 12'o7777);
        poke(0, 12'o0214, mk(5, 0, 1, 7'o14));
        poke(0, 12'o0261, mk(1, 0, 1, 7'o70));
        poke(0, 12'o0262, mk(5, 1, 1, 7'o60));
        poke(0, 12'o0250, 12'o7000);
        poke(0, 12'o0270, 12'o0003);
        poke(0, 12'o0030, 12'o1400);
        poke(0, 12'o0031, 12'o7777);
        poke(0, 12'o0032, 12'o0125);
        poke(0, 12'o0034, 12'o7776);
        run_prog(12'o0200, 3'd0, 3'd0, 14);

        // program B: separate fields, pointer windows, pc wrap
        poke(2, 12'o7776, 12'o6123);
        poke(2, 12'o7777, 12'o7456);
        poke(2, 12'o0000, mk(1, 1, 0, 7'o10));
        poke(2, 12'o0001, mk(1, 1, 0, 7'o10));
        poke(2, 12'o0002, mk(3, 1, 0, 7'o20));
        poke(2, 12'o0003, mk(1, 0, 0, 7'o20));
        poke(2, 12'o0004, mk(2, 1, 0, 7'o17));
        poke(2, 12'o0005, mk(1, 0, 0, 7'o20));
        poke(2, 12'o0006, mk(4, 1, 0, 7'o21));
        poke(2, 12'o0007, mk(5, 0, 0, 7'o40));
        poke(2, 12'o0010, 12'o0277);
        poke(2, 12'o0011, 12'o7777);
        poke(2, 12'o0017, 12'o7777);
        poke(2, 12'o0020, 12'o0400);
        poke(2, 12'o0021, 12'o3000);
        poke(2, 12'o0022, 12'o0500);
        poke(2, 12'o0040, mk(0, 1, 0, 7'o22));
        poke(2, 12'o0041, mk(5, 0, 1, 7'o41));
        poke(2, 12'o3001, mk(1, 1, 0, 7'o11));
        poke(2, 12'o3002, mk(5, 1, 1, 7'o00));
        poke(5, 12'o0300, 12'o1234);
        poke(5, 12'o0301, 12'o0001);
        poke(5, 12'o0000, 12'o7777);
        poke(5, 12'o0500, 12'o0700);
        run_prog(12'o7776, 3'd2, 3'd5, 14);

        // programs C: random AND / add / store-clear mixes on page zero
        for (int r = 0; r < 3; r++) begin
            for (int k = 0; k < 32; k++)
                poke(1, 12'(12'o40 + k), 12'($urandom_range(0, 4095)));
            for (int k = 0; k < 40; k++) begin
                int sel = int'($urandom_range(0, 2));
                poke(1, 12'(12'o200 + k),
                     mk((sel == 2) ? 3 : sel, 0, 0, 8'o40 + int'($urandom_range(0, 31))));
            end
            poke(1, 12'o0250, mk(5, 0, 1, 7'o50));
            run_prog(12'o0200, 3'd1, 3'd1, 41);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule